// File: doc/BRIEF.md
# Two-Wire Register Slave with Pointer Select

This block is the serial front end of an on-board thermal sensor. A host on a two-wire open-drain bus addresses the device, writes a one-byte pointer that selects one of a small bank of 16-bit registers, and then writes or reads that register as two bytes, high byte first. The register bank is outside this block. The block presents the selected index, a read-data input, and a one-cycle write strobe with a 16-bit word.

The 7-bit device address is a fixed upper nibble followed by three strap inputs, so up to eight of these devices can share a bus. The straps are latched at every START condition. When the timeout enable is set and the bus stalls with the clock held low during a transfer, the block releases the data line after a programmed number of system clocks and its protocol engine returns to idle. Both bus lines pass through input synchronizers. The block drives each line only through a drive-low enable, and it never stretches the clock.

Top module: `twi_regbank_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0011 followed by the latched straps (strap bit 2 first). On any other address it leaves SDA released for the acknowledge bit and ignores the bus until the next START.
- R2: The straps are captured at each START. A strap change after a START has no effect until the next START.
- R3: In a write transfer, the first data byte after the address loads the pointer. Its low PTR_W bits appear on rf_addr_o.
- R4: In a write transfer, the bytes after the pointer form words, high byte first. After every second such byte, rf_wr_o pulses for exactly one clock with that word on rf_wdata_o. Every data byte of a write is acknowledged.
- R5: In a read transfer, the block sends the selected register high byte then low byte, MSB first. It keeps alternating between the two bytes while the master acknowledges. SDA changes only while SCL is low.
- R6: A read with no pointer byte in the same transfer returns the register selected by the most recent pointer write.
- R7: When the master answers a read byte with NACK, the block releases SDA and drives nothing until the next START.
- R8: With tout_en_i high and a transfer in progress, SCL held low for TOUT_CYCLES system clocks releases SDA. The engine returns to idle and acknowledges nothing until a new START.
- R9: With tout_en_i low, a stalled SCL never causes the block to release an SDA low that it is driving.
- R10: After reset and after any STOP, SDA and SCL are released and rf_wr_o is low. After reset the pointer is 0. After a STOP, bytes clocked without a START receive no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_low_o | output | 1 | SCL drive-low enable (always 0) |
| sda_low_o | output | 1 | SDA drive-low enable |
| strap_i | input | 3 | Address straps, bit 2 is the most significant |
| tout_en_i | input | 1 | Enables the stalled-clock timeout |
| rf_addr_o | output | PTR_W | Selected register index (pointer) |
| rf_rdata_i | input | 16 | Read data of the selected register |
| rf_wr_o | output | 1 | One-cycle register write strobe |
| rf_wdata_o | output | 16 | Register write data |

## Verification
The bench changes the straps between a START and its address byte. A block that latched the straps late, or sampled them only once, would acknowledge the wrong address. It writes two words in one transfer and then reads with and without a fresh pointer. A block that let later bytes reload the pointer, or that lost the pointer between transfers, would return wrong bytes. It reads past the end of a word and clocks a byte after a master NACK, which exposes a block that keeps driving after a NACK or wraps to the wrong half of the word. It stalls SCL during an acknowledge with the timeout on and off. A counter that ignores the enable, or an engine that does not go idle, shows up as a held line or as a stray acknowledge.

// File: rtl/twi_rs_pkg.sv
package twi_rs_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } eng_state_e;

    // write-phase: what the next received data byte means
    typedef enum logic [1:0] {
        WP_POINTER,
        WP_HIGH,
        WP_LOW
    } wr_phase_e;
endpackage

// File: rtl/twi_rs_linecond.sv
module twi_rs_linecond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] syn;
    logic [NLINES-1:0] prev_q;

    assign raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] ff_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '1;
                else        ff_q <= {ff_q[STAGES-2:0], raw[g]};
            end
            assign syn[g] = ff_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= syn;
    end

    assign scl_s      = syn[0];
    assign sda_s      = syn[1];
    assign start_o    = syn[0] & prev_q[0] & prev_q[1] & ~syn[1];
    assign stop_o     = syn[0] & prev_q[0] & ~prev_q[1] & syn[1];
    assign scl_rise_o = syn[0] & ~prev_q[0];
    assign scl_fall_o = ~syn[0] & prev_q[0];
endmodule

// File: rtl/twi_rs_timeout.sv
module twi_rs_timeout #(
    parameter int LIMIT = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic busy_i,
    input  logic scl_s,
    output logic fire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          armed;

    always_comb begin
        armed  = en_i & busy_i & ~scl_s;
        fire_o = armed && (cnt_q == CW'(LIMIT - 1));
        if (!armed || fire_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/twi_rs_engine.sv
module twi_rs_engine
    import twi_rs_pkg::*;
#(
    parameter int         PTR_W   = 4,
    parameter logic [3:0] DEV_TAG = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              tmo_i,
    input  logic [2:0]        strap_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              busy_o,
    output logic              sda_low_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              wr_o,
    output logic [WORD_W-1:0] wdata_o
);
    typedef struct packed {
        eng_state_e        st;
        logic [2:0]        bitc;
        logic [BYTE_W-1:0] shreg;
        logic              done;
        logic              rw;
        wr_phase_e         wph;
        logic [BYTE_W-1:0] hi;
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] tx;
        logic [WORD_W-1:0] word;
        logic              bsel;
        logic              mack;
        logic              sda_low;
        logic              wr;
        logic [WORD_W-1:0] wdata;
        logic [2:0]        strap;
    } eng_t;

    eng_t d, q;
    logic [BYTE_W-1:0] next_tx;

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        next_tx = q.bsel ? q.word[BYTE_W-1:0] : q.word[WORD_W-1:BYTE_W];
        if (tmo_i) begin
            d.st      = ST_IDLE;
            d.sda_low = 1'b0;
            d.done    = 1'b0;
        end else if (start_i) begin
            d.st      = ST_ADDR;
            d.bitc    = '0;
            d.done    = 1'b0;
            d.sda_low = 1'b0;
            d.strap   = strap_i;
            d.wph     = WP_POINTER;
        end else if (stop_i) begin
            d.st      = ST_IDLE;
            d.sda_low = 1'b0;
            d.done    = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise_i) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bitc  = q.bitc + 3'd1;
                        if (q.bitc == 3'd7) d.done = 1'b1;
                    end else if (scl_fall_i && q.done) begin
                        d.done = 1'b0;
                        d.bitc = '0;
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[BYTE_W-1:1] == {DEV_TAG, q.strap}) begin
                                d.st      = ST_ADDR_ACK;
                                d.sda_low = 1'b1;
                                d.rw      = q.shreg[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st      = ST_WR_ACK;
                            d.sda_low = 1'b1;
                            unique case (q.wph)
                                WP_POINTER: begin
                                    d.ptr = q.shreg[PTR_W-1:0];
                                    d.wph = WP_HIGH;
                                end
                                WP_HIGH: begin
                                    d.hi  = q.shreg;
                                    d.wph = WP_LOW;
                                end
                                default: begin
                                    d.wr    = 1'b1;
                                    d.wdata = {q.hi, q.shreg};
                                    d.wph   = WP_HIGH;
                                end
                            endcase
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.bitc = '0;
                        if (q.rw) begin
                            d.word    = rdata_i;
                            d.tx      = rdata_i[WORD_W-1:BYTE_W];
                            d.bsel    = 1'b1;
                            d.sda_low = ~rdata_i[WORD_W-1];
                            d.st      = ST_RD_BYTE;
                        end else begin
                            d.sda_low = 1'b0;
                            d.st      = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        d.sda_low = 1'b0;
                        d.st      = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall_i) begin
                        if (q.bitc == 3'd7) begin
                            d.sda_low = 1'b0;
                            d.bitc    = '0;
                            d.st      = ST_RD_ACK;
                        end else begin
                            d.tx      = {q.tx[BYTE_W-2:0], 1'b0};
                            d.sda_low = ~q.tx[BYTE_W-2];
                            d.bitc    = q.bitc + 3'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.tx      = next_tx;
                            d.bsel    = ~q.bsel;
                            d.sda_low = ~next_tx[BYTE_W-1];
                            d.bitc    = '0;
                            d.st      = ST_RD_BYTE;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.wph   <= WP_POINTER;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign sda_low_o = q.sda_low;
    assign ptr_o     = q.ptr;
    assign wr_o      = q.wr;
    assign wdata_o   = q.wdata;

    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !q.sda_low);
    assert_tout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_i |=> (q.st == ST_IDLE && !q.sda_low));
    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(q.strap));
    assert_drive_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sda_low) |-> !scl_s);
    assert_nack_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !start_i) |=> !q.sda_low);
endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave
    import twi_rs_pkg::*;
#(
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2,
    parameter int         TOUT_CYCLES = 3_000_000,
    parameter logic [3:0] DEV_TAG     = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    input  logic [2:0]        strap_i,
    input  logic              tout_en_i,
    output logic [PTR_W-1:0]  rf_addr_o,
    input  logic [WORD_W-1:0] rf_rdata_i,
    output logic              rf_wr_o,
    output logic [WORD_W-1:0] rf_wdata_o
);
    logic scl_s, sda_s, start, stop, scl_rise, scl_fall;
    logic tmo, busy;

    twi_rs_linecond #(.STAGES(SYNC_STAGES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_o   (start),
        .stop_o    (stop),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall)
    );

    twi_rs_timeout #(.LIMIT(TOUT_CYCLES)) u_tout (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (tout_en_i),
        .busy_i(busy),
        .scl_s (scl_s),
        .fire_o(tmo)
    );

    twi_rs_engine #(.PTR_W(PTR_W), .DEV_TAG(DEV_TAG)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_i   (start),
        .stop_i    (stop),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .tmo_i     (tmo),
        .strap_i   (strap_i),
        .rdata_i   (rf_rdata_i),
        .busy_o    (busy),
        .sda_low_o (sda_low_o),
        .ptr_o     (rf_addr_o),
        .wr_o      (rf_wr_o),
        .wdata_o   (rf_wdata_o)
    );

    assign scl_low_o = 1'b0;
endmodule

// File: tb/twi_regbank_slave_tb.sv
`timescale 1ns/1ps
module twi_regbank_slave_tb;
    localparam int PTR_W = 4;
    localparam int TOUT  = 300;
    localparam int QT    = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic tout_en = 1'b0;
    logic scl_low, sda_low, rf_wr;
    logic [PTR_W-1:0] rf_addr;
    logic [15:0] rf_wdata, rf_rdata;
    logic [15:0] mem [16];
    logic scl_line, sda_line;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [PTR_W+15:0] exp_q [$];

    always #5 clk = ~clk;

    assign scl_line = scl_m & ~scl_low;
    assign sda_line = sda_m & ~sda_low;
    assign rf_rdata = mem[rf_addr];

    twi_regbank_slave #(.PTR_W(PTR_W), .TOUT_CYCLES(TOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_low_o(scl_low), .sda_low_o(sda_low), .strap_i(strap),
        .tout_en_i(tout_en), .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata),
        .rf_wr_o(rf_wr), .rf_wdata_o(rf_wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected writes (R4)
    always @(negedge clk) begin
        if (rst_n && rf_wr) begin
            mem[rf_addr] <= rf_wdata;
            if (exp_q.size() == 0) begin
                chk(0, "R4 unexpected write", int'({rf_addr, rf_wdata}), 0);
            end else begin
                logic [PTR_W+15:0] e;
                e = exp_q.pop_front();
                chk({rf_addr, rf_wdata} == e, "R4 write word", int'({rf_addr, rf_wdata}), int'(e));
            end
        end
    end

    task automatic bus_start();
        sda_m = 1; scl_m = 1; #QT;
        sda_m = 0; #QT;
        scl_m = 0; #QT;
    endtask
    task automatic bus_stop();
        sda_m = 0; #QT;
        scl_m = 1; #QT;
        sda_m = 1; #QT;
    endtask
    task automatic wbit(input logic b);
        sda_m = b; #QT;
        scl_m = 1; #(2*QT);
        scl_m = 0; #QT;
    endtask
    task automatic rbit(output logic b);
        sda_m = 1; #QT;
        scl_m = 1; #QT;
        b = sda_line; #QT;
        scl_m = 0; #QT;
    endtask
    task automatic send(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = (a == 1'b0);
    endtask
    task automatic recv(output logic [7:0] v, input bit last);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        wbit(last);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 16; i++) mem[i] = 16'h0100 * i[15:0] + 16'h0011;
        mem[2] = 16'h1A5C;
        #33; rst_n = 1; #50;
        @(negedge clk);
        chk(sda_low == 0, "R10 reset sda", sda_low, 0);
        chk(scl_low == 0, "R10 reset scl", scl_low, 0);
        chk(rf_wr == 0, "R10 reset wr", rf_wr, 0);
        chk(rf_addr == 0, "R10 reset pointer", rf_addr, 0);

        // R1 wrong address
        bus_start(); send(8'h50, ack); chk(!ack, "R1 foreign address nack", ack, 0);
        send(8'h05, ack); chk(!ack, "R1 ignored after mismatch", ack, 0);
        bus_stop();

        // R1 R3 R4 pointer then two words
        bus_start(); send(8'h3A, ack); chk(ack, "R1 own address ack", ack, 1);
        send(8'h05, ack); chk(ack, "R4 pointer byte ack", ack, 1);
        chk(rf_addr == 5, "R3 pointer loaded", rf_addr, 5);
        exp_q.push_back({4'd5, 16'hBEEF});
        send(8'hBE, ack); chk(ack, "R4 high byte ack", ack, 1);
        send(8'hEF, ack); chk(ack, "R4 low byte ack", ack, 1);
        chk(mem[5] == 16'hBEEF, "R4 word stored", mem[5], 16'hBEEF);
        exp_q.push_back({4'd5, 16'h1234});
        send(8'h12, ack); send(8'h34, ack);
        chk(ack && rf_addr == 5, "R3 pointer not reloaded", rf_addr, 5);
        bus_stop();

        // R5 pointer then repeated start read
        bus_start(); send(8'h3A, ack); send(8'h05, ack);
        bus_start(); send(8'h3B, ack); chk(ack, "R1 read address ack", ack, 1);
        recv(b, 0); chk(b == 8'h12, "R5 read high byte", b, 8'h12);
        recv(b, 1); chk(b == 8'h34, "R5 read low byte", b, 8'h34);
        bus_stop();

        // R6 read without pointer
        bus_start(); send(8'h3B, ack);
        recv(b, 0); chk(b == 8'h12, "R6 last pointer high", b, 8'h12);
        recv(b, 1); chk(b == 8'h34, "R6 last pointer low", b, 8'h34);
        bus_stop();

        // R5 wrap and R7 nack end
        bus_start(); send(8'h3A, ack); send(8'h02, ack);
        bus_start(); send(8'h3B, ack);
        recv(b, 0); chk(b == 8'h1A, "R5 reg2 high", b, 8'h1A);
        recv(b, 0); chk(b == 8'h5C, "R5 reg2 low", b, 8'h5C);
        recv(b, 1); chk(b == 8'h1A, "R5 wrap high", b, 8'h1A);
        recv(b, 1); chk(b == 8'hFF, "R7 no drive after nack", b, 8'hFF);
        bus_stop();

        // R10 stop mid write
        bus_start(); send(8'h3A, ack); send(8'h07, ack); bus_stop();
        chk(sda_line == 1, "R10 released after stop", sda_line, 1);
        send(8'h3A, ack); chk(!ack, "R10 no ack without start", ack, 0);
        chk(rf_addr == 7, "R3 pointer kept", rf_addr, 7);
        bus_stop();

        // R2 straps latched at start
        bus_start(); strap = 3'b010; #QT;
        send(8'h3A, ack); chk(ack, "R2 old strap used in transfer", ack, 1);
        bus_stop();
        bus_start(); send(8'h3A, ack); chk(!ack, "R2 old address rejected", ack, 0);
        bus_stop();
        bus_start(); send(8'h34, ack); chk(ack, "R2 new address ack", ack, 1);
        bus_stop();

        // R9 timeout disabled
        tout_en = 0;
        bus_start(); send(8'h34, ack);
        // after the ack bit the block now waits; stall during next ack via new address
        bus_stop();
        bus_start();
        for (int i = 7; i >= 0; i--) wbit(8'h34 >> i);
        sda_m = 1; #(TOUT * 14);
        chk(sda_line == 0, "R9 held while disabled", sda_line, 0);
        rbit(b[0]); bus_stop();

        // R8 timeout enabled
        tout_en = 1;
        bus_start();
        for (int i = 7; i >= 0; i--) wbit(8'h34 >> i);
        sda_m = 1; #(QT / 2);
        chk(sda_line == 0, "R8 ack driven before stall", sda_line, 0);
        #(TOUT * 14);
        chk(sda_line == 1, "R8 released by timeout", sda_line, 1);
        send(8'h34, ack); chk(!ack, "R8 idle after timeout", ack, 0);
        bus_stop();

        #200;
        chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule